// File: doc/BRIEF.md
# Bitwise Three-Input Truth-Table Unit

This unit evaluates any boolean function of three inputs at every bit position of three XLEN-wide words at the same time. Each result bit comes from a lookup into an 8-entry truth table. The three input bits at that position form the 3-bit index. The previous destination value is one of the three inputs, so a surrounding pipeline feeds the old destination word in and writes the result back over it.

There are two table sources. The first is an 8-bit immediate that arrives in two pieces, a 5-bit low piece and a 3-bit high piece. The second is the low byte of a fourth operand word. The two sources build the index from the input bits in different orders. A 2-bit variant field travels with each operation; it is accepted and has no effect on the result. The unit registers its result with a latency of one cycle and accepts a new operation every cycle.

Top module: `tlu_ternlog_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and result are both zero after that edge.
- R2: With tbl_from_reg = 0, result bit i equals table bit k, where k = op_b[i]*4 + op_a[i]*2 + dest_in[i]. Table entry 0 is bit 0 of the table.
- R3: With tbl_from_reg = 0, the table is built as {imm_hi, imm_lo}. Table bits 4..0 are imm_lo[4:0] and table bits 7..5 are imm_hi[2:0].
- R4: With tbl_from_reg = 1, result bit i equals tbl_word[k], where k = dest_in[i]*4 + op_a[i]*2 + op_b[i].
- R5: With tbl_from_reg = 1, bits XLEN-1..8 of tbl_word have no effect on the result.
- R6: The 2-bit variant field has no effect on the result for any of its four values.
- R7: An operation presented with in_valid = 1 at a clock edge appears on result, with out_valid = 1, right after that edge. Operations may be issued back to back, and each one may use either table source.
- R8: A clock edge with in_valid = 0 leaves result unchanged and sets out_valid to 0.
- R9: With immediate 0xCA, the result equals (op_a & op_b) | (dest_in & ~op_b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| tbl_from_reg | input | 1 | 0: the immediate is the table, 1: the low byte of tbl_word is the table |
| variant | input | 2 | Variant field, accepted and ignored |
| dest_in | input | XLEN | Old destination word, an index input |
| op_a | input | XLEN | First source word |
| op_b | input | XLEN | Second source word |
| tbl_word | input | XLEN | Table operand for register mode |
| imm_lo | input | 5 | Immediate table bits 4..0 |
| imm_hi | input | 3 | Immediate table bits 7..5 |
| out_valid | output | 1 | Result is for an operation issued on the previous edge |
| result | output | XLEN | Registered result word |

## Verification
Two things can happen in one cycle: the result of one operation is captured, and the next operation, using the other table source and the other index order, is presented. The stimulus therefore keeps in_valid high without a gap and alternates between immediate mode and register mode. Each result is compared one cycle later against a bit-by-bit model built from the requirements. Any mix-up of table source or index order between neighbouring operations then shows up as a mismatch. Every immediate value and every register table byte is swept, with random operands, random upper table bits and a random variant field.

// File: rtl/tlu_pkg.sv
// Package: shared constants and types for the three-input truth-table unit.
// Assumes a table of 8 entries indexed by 3 bits.
package tlu_pkg;
    localparam int TBL_W   = 8;
    localparam int IDX_W   = 3;
    localparam int IMM_LO_W = 5;
    localparam int IMM_HI_W = TBL_W - IMM_LO_W;

    typedef enum logic {
        SRC_IMM = 1'b0,
        SRC_REG = 1'b1
    } tbl_src_e;
endpackage

// File: rtl/tlu_table_sel.sv
// tlu_table_sel: picks the 8-entry truth table from the split immediate
// or from the low byte of the table operand. Assumes XLEN >= TBL_W.
module tlu_table_sel
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  tbl_src_e                src,
    input  logic [IMM_LO_W-1:0]     imm_lo,
    input  logic [IMM_HI_W-1:0]     imm_hi,
    input  logic [TBL_W-1:0]        tbl_low,
    output logic [TBL_W-1:0]        table_out
);
    // Choose the table source; the immediate is rebuilt high-over-low.
    always_comb begin
        if (src == SRC_REG) table_out = tbl_low;
        else                table_out = {imm_hi, imm_lo};
    end

    initial begin
        assert (XLEN >= TBL_W) else $error("XLEN too small for table");
    end
endmodule

// File: rtl/tlu_lut_lane.sv
// tlu_lut_lane: one bit position. Forms the 3-bit index in the order the
// table source requires and selects one table entry (entry 0 = bit 0).
module tlu_lut_lane
    import tlu_pkg::*;
(
    input  tbl_src_e           src,
    input  logic               bit_d,
    input  logic               bit_a,
    input  logic               bit_b,
    input  logic [TBL_W-1:0]   table_in,
    output logic               bit_out
);
    logic [IDX_W-1:0] idx;

    // Immediate mode: b is the high bit; register mode: the destination is.
    always_comb begin
        if (src == SRC_REG) idx = {bit_d, bit_a, bit_b};
        else                idx = {bit_b, bit_a, bit_d};
    end

    // Look up the selected entry.
    always_comb bit_out = table_in[idx];
endmodule

// File: rtl/tlu_ternlog_unit.sv
// tlu_ternlog_unit: XLEN-wide three-input truth-table evaluator with a
// registered result (one cycle latency, one operation per cycle).
// Assumes the caller writes the result back over the destination word.
module tlu_ternlog_unit
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              tbl_from_reg,
    input  logic [1:0]        variant,
    input  logic [XLEN-1:0]   dest_in,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic [XLEN-1:0]   tbl_word,
    input  logic [4:0]        imm_lo,
    input  logic [2:0]        imm_hi,
    output logic              out_valid,
    output logic [XLEN-1:0]   result
);
    localparam int HI_W = XLEN - TBL_W;

    tbl_src_e          src;
    logic [TBL_W-1:0]  table_sel;
    logic [XLEN-1:0]   comb_res;

    // Map the select pin onto the table source type.
    always_comb src = tbl_src_e'(tbl_from_reg);

    tlu_table_sel #(.XLEN(XLEN)) u_tsel (
        .src       (src),
        .imm_lo    (imm_lo),
        .imm_hi    (imm_hi),
        .tbl_low   (tbl_word[TBL_W-1:0]),
        .table_out (table_sel)
    );

    for (genvar i = 0; i < XLEN; i++) begin : g_lane
        tlu_lut_lane u_lane (
            .src      (src),
            .bit_d    (dest_in[i]),
            .bit_a    (op_a[i]),
            .bit_b    (op_b[i]),
            .table_in (table_sel),
            .bit_out  (comb_res[i])
        );
    end

    // Result register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= comb_res;
        end
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid lost"); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && !out_valid)) else $error("idle changed result"); // R8

    AST_IMM_ZERO_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !tbl_from_reg && imm_lo == 5'd0 && imm_hi == 3'd0) |=> (result == '0))
        else $error("zero table gave ones"); // R2

    AST_IMM_SELECT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !tbl_from_reg && imm_lo == 5'h10 && imm_hi == 3'h7) |=> (result == $past(op_b)))
        else $error("0xF0 immediate did not pass op_b"); // R3

    AST_REG_SELECT_D: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tbl_from_reg && tbl_word[TBL_W-1:0] == 8'hF0) |=> (result == $past(dest_in)))
        else $error("register table 0xF0 did not pass dest_in"); // R4

    AST_VARIANT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(in_valid) && !$stable(variant) && $stable(dest_in) && $stable(op_a)
         && $stable(op_b) && $stable(tbl_word[TBL_W-1:0]) && $stable(tbl_from_reg)
         && $stable(imm_lo) && $stable(imm_hi)) |=> $stable(result))
        else $error("variant changed result"); // R6

    AST_UPPER_TBL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(in_valid) && tbl_from_reg && $past(tbl_from_reg)
         && !$stable(tbl_word[XLEN-1:XLEN-HI_W]) && $stable(dest_in) && $stable(op_a)
         && $stable(op_b) && $stable(tbl_word[TBL_W-1:0])) |=> $stable(result))
        else $error("upper table bits changed result"); // R5
endmodule

// File: tb/tb_tlu_ternlog_unit.sv
// Bench: sweeps every immediate and every register table byte back to back,
// alternating table sources, against a bit-serial model of the requirements.
module tb_tlu_ternlog_unit;
    localparam int XLEN = 64;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 100000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            tbl_from_reg;
    logic [1:0]      variant;
    logic [XLEN-1:0] dest_in, op_a, op_b, tbl_word;
    logic [4:0]      imm_lo;
    logic [2:0]      imm_hi;
    logic            out_valid;
    logic [XLEN-1:0] result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlu_ternlog_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tbl_from_reg(tbl_from_reg),
        .variant(variant), .dest_in(dest_in), .op_a(op_a), .op_b(op_b),
        .tbl_word(tbl_word), .imm_lo(imm_lo), .imm_hi(imm_hi),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [XLEN-1:0] rnd();
        return {$urandom(), $urandom()};
    endfunction

    // Bit-serial model: R2/R3 immediate order, R4/R5 register order.
    function automatic logic [XLEN-1:0] model(logic from_reg, logic [XLEN-1:0] d,
            logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic [XLEN-1:0] tw,
            logic [4:0] lo, logic [2:0] hi);
        logic [XLEN-1:0] r;
        logic [7:0] t;
        int k;
        t = from_reg ? tw[7:0] : {hi, lo};
        for (int i = 0; i < XLEN; i++) begin
            if (from_reg) k = 4*int'(d[i]) + 2*int'(a[i]) + int'(b[i]);
            else          k = 4*int'(b[i]) + 2*int'(a[i]) + int'(d[i]);
            r[i] = t[k];
        end
        return r;
    endfunction

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic fr, logic [XLEN-1:0] d, logic [XLEN-1:0] a,
            logic [XLEN-1:0] b, logic [XLEN-1:0] tw, logic [7:0] imm, logic [1:0] var_f);
        in_valid = v; tbl_from_reg = fr; dest_in = d; op_a = a; op_b = b;
        tbl_word = tw; imm_lo = imm[4:0]; imm_hi = imm[7:5]; variant = var_f;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] d, a, b, tw, held, ref_r;
        rst_n = 1'b0;
        drive(1'b1, 1'b0, '1, '1, '1, '1, 8'hFF, 2'd0);
        @(negedge clk); @(negedge clk);
        chk("R1 valid", {63'd0, out_valid}, '0);
        chk("R1 result", result, '0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R7: back-to-back, alternating immediate and register sources.
        for (int v = 0; v < 256; v++) begin
            d = rnd(); a = rnd(); b = rnd();
            tw = {rnd() >> 8, 8'h00} | XLEN'(v[7:0] ^ 8'h5A);
            drive(1'b1, 1'b0, d, a, b, tw, v[7:0], 2'($urandom()));
            @(negedge clk);
            chk("R2 R3 immediate sweep", result, model(1'b0, d, a, b, tw, v[4:0], v[7:5]));
            if (!out_valid) chk("R7 out_valid", 64'd0, 64'd1);
            d = rnd(); a = rnd(); b = rnd();
            tw = {rnd() >> 8, v[7:0]};
            drive(1'b1, 1'b1, d, a, b, tw, 8'($urandom()), 2'($urandom()));
            @(negedge clk);
            chk("R4 R5 register sweep", result, model(1'b1, d, a, b, tw, 5'd0, 3'd0));
        end

        // R3: each immediate half lands in its own table bits.
        d = 64'h00FF00FF00FF00FF; a = 64'h0F0F0F0F0F0F0F0F; b = 64'h3333333333333333;
        drive(1'b1, 1'b0, d, a, b, '0, 8'h1F, 2'd0);
        @(negedge clk);
        chk("R3 low half", result, model(1'b0, d, a, b, '0, 5'h1F, 3'h0));
        drive(1'b1, 1'b0, d, a, b, '0, 8'hE0, 2'd0);
        @(negedge clk);
        chk("R3 high half", result, model(1'b0, d, a, b, '0, 5'h00, 3'h7));

        // R5: only the upper table bits change between two register operations.
        d = rnd(); a = rnd(); b = rnd();
        drive(1'b1, 1'b1, d, a, b, {56'h0, 8'h96}, 8'h00, 2'd0);
        @(negedge clk);
        ref_r = result;
        drive(1'b1, 1'b1, d, a, b, {56'hFFFF_FFFF_FFFF_FF, 8'h96}, 8'h00, 2'd0);
        @(negedge clk);
        chk("R5 upper table bits", result, ref_r);

        // R6: all four variant values give the same result.
        d = rnd(); a = rnd(); b = rnd();
        for (int m = 0; m < 4; m++) begin
            drive(1'b1, m[0], d, a, b, {56'h0, 8'h6B}, 8'hB2, 2'(m));
            @(negedge clk);
            chk("R6 variant ignored", result, model(m[0], d, a, b, {56'h0, 8'h6B}, 5'h12, 3'h5));
        end

        // R9: conditional mix through immediate 0xCA.
        for (int n = 0; n < 4; n++) begin
            d = rnd(); a = rnd(); b = rnd();
            drive(1'b1, 1'b0, d, a, b, rnd(), 8'hCA, 2'd3);
            @(negedge clk);
            chk("R9 conditional mix", result, (a & b) | (d & ~b));
        end

        // R8: idle edge keeps the result, drops out_valid.
        held = result;
        drive(1'b0, 1'b1, rnd(), rnd(), rnd(), rnd(), 8'h3C, 2'd1);
        @(negedge clk);
        chk("R8 result held", result, held);
        chk("R8 out_valid low", {63'd0, out_valid}, '0);

        // R7: a single valid after idle appears one edge later.
        d = rnd(); a = rnd(); b = rnd();
        drive(1'b1, 1'b0, d, a, b, '0, 8'h96, 2'd0);
        @(negedge clk);
        chk("R7 out_valid", {63'd0, out_valid}, 64'd1);
        chk("R7 result", result, d ^ a ^ b);

        // R1: reset in mid-stream clears both outputs.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset result", result, '0);
        chk("R1 reset valid", {63'd0, out_valid}, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule